// File: doc/BRIEF.md
# Sequential BCD-to-Binary Converter

This block turns an operand of `DIGITS` packed decimal digits into an unsigned binary word. It works one bit per clock. A scratch register holds the decimal digits in its upper part and the binary result in its lower part. On each step the whole register moves one bit to the right. The lowest decimal bit enters the top of the binary part. Then every decimal nibble that reads 8 or more has 3 taken away. This undoes the add-3 rule of the forward conversion.

The result is `RES_W = ceil(log2(10^DIGITS))` bits wide, so it can hold every value up to `10^DIGITS - 1`. A conversion takes exactly `RES_W` steps. A caller pulses `start` with the operand while the block is idle. It then waits for the one-cycle `done` pulse and reads `result`. It also reads `error`, which marks an operand that held a nibble above 9. In that case the result value is unspecified.

Top module: `bcd2bin_seq`

## Requirements
- R1: While reset is applied and in the first idle cycle after it, `busy`, `done` and `error` are low and `result` is zero.
- R2: A `start` sampled high while idle loads the operand into the digit part and clears the binary part. In the following cycle `busy` is high and `result` reads zero.
- R3: For an operand with every nibble in 0..9, the final `result` equals the sum over k of nibble k times 10^k. Nibble k occupies bits [4k+3:4k] of `bcdIn`.
- R4: `busy` stays high for exactly `RES_W` cycles after the accepting edge. `done` rises in the same cycle that `busy` falls.
- R5: `done` is high for exactly one cycle per conversion.
- R6: A `start` raised while `busy` is high is ignored. The running conversion completes on its original schedule with its original result.
- R7: After `done`, `result` and `error` keep their values until the next accepted `start`.
- R8: In the `done` cycle, `error` is high exactly when at least one operand nibble was greater than 9. Otherwise it is low.
- R9: The register shifts right and takes value bits least significant first. For a valid operand of value V, after j steps (1 <= j <= `RES_W`) `result` equals (V mod 2^j) shifted left by `RES_W - j`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of `bcdIn` (accepted only when idle) |
| bcdIn | input | 4*DIGITS | Packed decimal operand, digit 0 in the low nibble |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| error | output | 1 | Operand contained a nibble above 9 |
| result | output | RES_W | Binary value (partial while busy) |

## Verification
The hardest situation to bring about is a second `start` arriving in the middle of a conversion. The bench places that strobe on a chosen step and gives it a different operand. It then checks that the step timing, the partial results and the final value all follow the first operand. The per-nibble subtract-3 correction cannot be seen directly at the ports. It is pinned down by checking the partial result after every single step against the low bits of the expected value. The checks use operands that need corrections on several digits, such as 243, 999 and 907.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;

  // Width of an unsigned word that can hold 10^digits - 1.
  function automatic int resultWidth(input int digits);
    longint unsigned limit;
    int w;
    limit = 1;
    for (int k = 0; k < digits; k++) limit = limit * 10;
    w = 0;
    while ((longint'(1) << w) < limit) w++;
    return w;
  endfunction

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture a new operand, clear the binary part
    logic step;   // one shift-right-and-correct iteration
  } dpCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/bcd2bin_ctrl.sv
module bcd2bin_ctrl
  import bcd2bin_pkg::*;
#(
  parameter int STEPS = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output dpCtrl_t dpCtrl,
  output logic    busy,
  output logic    done
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] stepCnt;
  logic accept;
  logic lastStep;

  assign accept   = start && (state == ST_IDLE);
  assign lastStep = (state == ST_RUN) && (stepCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            state   <= ST_IDLE;
            stepCnt <= '0;
            done    <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.load = accept;
    dpCtrl.step = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);

  // R4: the final step ends the run and raises done.
  a_r4_last_step_ends: assert property (@(posedge clk) disable iff (rst)
    lastStep |=> (done && !busy));

  // R5: done never lasts two cycles.
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: a strobe during a run neither restarts nor stalls the count.
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lastStep) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

  // R4: busy only falls together with done.
  a_r4_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

// File: rtl/bcd2bin_datapath.sv
module bcd2bin_datapath
  import bcd2bin_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int RES_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpCtrl_t               dpCtrl,
  input  logic [4*DIGITS-1:0]   bcdIn,
  output logic [RES_W-1:0]      result,
  output logic [4*DIGITS-1:0]   digitRem,
  output logic                  badDigit
);

  localparam int DIG_W = 4 * DIGITS;
  localparam int SCR_W = DIG_W + RES_W;

  logic [SCR_W-1:0] scratch;
  logic [SCR_W-1:0] shifted;
  logic [SCR_W-1:0] corrected;
  logic [DIGITS-1:0] nibbleBad;

  assign shifted = scratch >> 1;
  assign corrected[RES_W-1:0] = shifted[RES_W-1:0];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] nib;
    assign nib = shifted[RES_W + 4*g +: 4];
    // Undo the forward add-3: a nibble at 8 or above carried in a half-ten.
    assign corrected[RES_W + 4*g +: 4] = (nib >= 4'd8) ? (nib - 4'd3) : nib;
    assign nibbleBad[g] = (bcdIn[4*g +: 4] > 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch  <= '0;
      badDigit <= 1'b0;
    end else if (dpCtrl.load) begin
      scratch  <= {bcdIn, {RES_W{1'b0}}};
      badDigit <= |nibbleBad;
    end else if (dpCtrl.step) begin
      scratch  <= corrected;
    end
  end

  assign result   = scratch[RES_W-1:0];
  assign digitRem = scratch[SCR_W-1:RES_W];

  // R7: with no strobe the scratch register holds its value.
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!dpCtrl.load && !dpCtrl.step) |=> ($stable(scratch) && $stable(badDigit)));

  // R2: a load leaves the binary part cleared.
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    dpCtrl.load |=> (result == '0));

endmodule

// File: rtl/bcd2bin_seq.sv
module bcd2bin_seq
  import bcd2bin_pkg::*;
#(
  parameter int DIGITS = 3,
  localparam int RES_W = resultWidth(DIGITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [4*DIGITS-1:0] bcdIn,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [RES_W-1:0]    result
);

  dpCtrl_t dpCtrl;
  logic [4*DIGITS-1:0] digitRem;
  logic badDigit;

  bcd2bin_ctrl #(
    .STEPS (RES_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dpCtrl (dpCtrl),
    .busy   (busy),
    .done   (done)
  );

  bcd2bin_datapath #(
    .DIGITS (DIGITS),
    .RES_W  (RES_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dpCtrl   (dpCtrl),
    .bcdIn    (bcdIn),
    .result   (result),
    .digitRem (digitRem),
    .badDigit (badDigit)
  );

  assign error = badDigit;

  // R3: a valid operand has been fully drained into the binary part.
  a_r3_digits_drained: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (digitRem == '0));

  // R1: idle outputs after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done));

endmodule

// File: tb/sim_bcd2bin_seq.sv
module sim_bcd2bin_seq;
  import bcd2bin_pkg::*;

  localparam int DIGITS = 3;
  localparam int RES_W  = resultWidth(DIGITS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [4*DIGITS-1:0] bcdIn = '0;
  logic busy, done, error;
  logic [RES_W-1:0] result;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  bcd2bin_seq #(.DIGITS(DIGITS)) u0 (
    .clk(clk), .rst(rst), .start(start), .bcdIn(bcdIn),
    .busy(busy), .done(done), .error(error), .result(result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint decValue(input logic [4*DIGITS-1:0] op);
    longint v = 0;
    for (int k = DIGITS - 1; k >= 0; k--) v = v * 10 + op[4*k +: 4];
    return v;
  endfunction

  function automatic bit hasBad(input logic [4*DIGITS-1:0] op);
    for (int k = 0; k < DIGITS; k++) if (op[4*k +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  // One conversion; pokeAt >= 1 raises start with a foreign operand at that step.
  task automatic runConvert(input logic [4*DIGITS-1:0] op, input int pokeAt);
    longint v = decValue(op);
    bit bad = hasBad(op);
    logic [RES_W-1:0] part;
    @(negedge clk);
    bcdIn = op;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    bcdIn = '0;
    check(busy === 1'b1 && result === '0, "R2", result, 0);
    for (int j = 1; j <= RES_W; j++) begin
      if (j == pokeAt) begin
        start = 1'b1;
        bcdIn = {DIGITS{4'h9}};
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (!bad) begin
        part = RES_W'((v & ((longint'(1) << j) - 1)) << (RES_W - j));
        check(result === part, (pokeAt > 0) ? "R6 partial" : "R9", result, part);
      end
      if (j < RES_W)
        check(busy === 1'b1 && done === 1'b0, "R4 running", {busy, done}, 2);
    end
    check(busy === 1'b0 && done === 1'b1, "R4 finish", {busy, done}, 1);
    check(error === bad, "R8", error, bad);
    if (!bad) check(result === RES_W'(v), (pokeAt > 0) ? "R6 result" : "R3", result, v);
    @(negedge clk);
    check(done === 1'b0, "R5", done, 0);
  endtask

  task automatic testReset();
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0 && result === '0,
          "R1", {busy, done, error}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0 && result === '0,
          "R1 after release", result, 0);
  endtask

  task automatic testHold(input logic [4*DIGITS-1:0] op);
    logic [RES_W-1:0] kept;
    logic keptErr;
    runConvert(op, 0);
    kept = result;
    keptErr = error;
    bcdIn = {DIGITS{4'h7}};
    repeat (6) @(negedge clk);
    check(result === kept && error === keptErr && done === 1'b0 && busy === 1'b0,
          "R7", result, kept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    runConvert(12'h243, 0);       // R3 corrections on middle and low digits
    runConvert(12'h000, 0);
    runConvert(12'h999, 0);
    runConvert(12'h500, 0);
    runConvert(12'h001, 0);
    runConvert(12'h2A3, 0);       // R8 error set
    runConvert(12'h907, 0);       // R8 error cleared again
    runConvert(12'h123, 3);       // R6 intruding start
    runConvert(12'h680, RES_W-1); // R6 intruding start late
    testHold(12'h456);            // R7
    testHold(12'hF05);            // R7 with error held
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule